// File: doc/BRIEF.md
# Chip-Walk Request Scheduler

This block sits between the host command queue of a many-chip flash storage device and its flash controllers. Each host I/O arrives as a tag whose memory requests have already been translated into physical targets: a chip number plus a die/plane location inside that chip, and a read or write direction. Admitting a tag only records its targets. No request composition and no data movement take place at this point. Tags keep being accepted for as long as a queue slot is free, and this continues while scheduling is in progress.

Scheduling is driven by the physical layout of the chips, not by the order in which I/Os arrived. A walker visits one chip per clock. The channel index steps fastest at a fixed chip offset, and the chip visited is `offset * N_CH + channel`, so consecutive visits land on different channels. On each visit, if the chip's ready/busy line shows ready, one pending request that targets the chip is committed. That request may belong to any queued tag. A busy chip is passed over and picked up again on the next lap.

Two ordering rules limit this freedom. While any queued tag is marked force-unit-access, only the oldest tag with uncommitted work may issue, one request at a time, lowest index first. A write is also held back while an older read to the same chip, die and plane has not been committed. A slot is released once every one of its requests has been committed and reported complete.

Top module: `chipwalk_sched`

## Requirements
- R1: `in_ready` is high exactly when a queue slot is free. `adm_slot` names the lowest-numbered free slot, and a tag offered with `in_valid` while `in_ready` is high is stored there at that clock edge. Admission continues while commits are being issued.
- R2: The walker visits one chip per cycle in ascending chip number, where chip = offset*N_CH + channel, and wraps from the last chip to chip 0. Each commit strobe appears one cycle after the visit that produced it, so commits issued on back-to-back cycles go to consecutive chip numbers on different channels.
- R3: At most one bit of `cmt_strobe` is set in any cycle. The strobed chip is the target of the request named by `cmt_tag` (slot number) and `cmt_idx` (request index, bit field r of `in_chip` being `[r*CW +: CW]`).
- R4: No commit goes to a chip whose `chip_busy` bit was high in its visit cycle. The chip is served on a later lap once it shows ready.
- R5: When no force-unit-access tag is queued, a ready chip with several eligible requests commits the one with the lowest slot number, then the lowest request index. Requests from different tags can therefore interleave on one chip.
- R6: While any queued tag has `in_fua`=1, only the lowest pending request index of the oldest tag that has uncommitted requests can be committed. No other chip commits, even if it is ready.
- R7: A write request (`in_rd` bit 0) is not committed while a read (`in_rd` bit 1) to the same chip and the same `in_loc` value (die/plane location), from an older tag or from a lower index of the same tag, is still uncommitted.
- R8: A slot becomes free only after all of its `in_nreq` requests are committed and each has been reported by `cmp_valid` with `cmp_tag`/`cmp_idx`. It frees on the second clock edge after the last completion, and a partly completed slot stays occupied.
- R9: Every admitted request is committed exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Host tag offered |
| in_fua | input | 1 | Tag requires strict arrival ordering |
| in_nreq | input | NW | Number of requests in the tag (1..MAXREQ) |
| in_chip | input | MAXREQ*CW | Target chip per request, request r at [r*CW +: CW] |
| in_loc | input | MAXREQ*LW | Die/plane location per request |
| in_rd | input | MAXREQ | Per request: 1 read, 0 write |
| in_ready | output | 1 | A slot is free |
| adm_slot | output | SW | Slot the next admitted tag takes |
| chip_busy | input | N_CHIP | Ready/busy line per chip, 1 = busy |
| cmp_valid | input | 1 | A committed request has completed |
| cmp_tag | input | SW | Slot of the completed request |
| cmp_idx | input | IW | Index of the completed request |
| cmt_strobe | output | N_CHIP | One-hot commit strobe per chip |
| cmt_tag | output | SW | Slot of the committed request |
| cmt_idx | output | IW | Index of the committed request |

## Verification
A corrupted walker position shows at the ports within one lap (N_CHIP cycles). Commits then stop following the ascending chip sequence, or they land on chips that differ from the target of the named request. Lost or stale commit bits show up as a request committed twice or never, and the scoreboard catches this at the next strobe on that chip or when the run drains. Wrong age or slot bookkeeping reverses the pair of commits in a write-after-read or force-unit-access scenario. It can also move `adm_slot`/`in_ready` two edges after a completion pulse, which is where the bench samples them.

// File: rtl/chipwalk_pkg.sv
package chipwalk_pkg;
  // chip number of a walker position
  function automatic int walk_chip(int off, int ch, int n_ch);
    return off * n_ch + ch;
  endfunction

  // flat candidate index <-> (slot, request)
  function automatic int flat_of(int slot, int idx, int maxreq);
    return slot * maxreq + idx;
  endfunction

  function automatic int slot_of(int flat, int maxreq);
    return flat / maxreq;
  endfunction

  function automatic int idx_of(int flat, int maxreq);
    return flat % maxreq;
  endfunction
endpackage

// File: rtl/chipwalk_walker.sv
module chipwalk_walker #(
  parameter int N_CH = 2,
  parameter int CPC  = 2,
  localparam int N_CHIP = N_CH * CPC,
  localparam int CW   = (N_CHIP > 1) ? $clog2(N_CHIP) : 1,
  localparam int CHW  = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int OFW  = (CPC > 1) ? $clog2(CPC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] visit_chip
);
  import chipwalk_pkg::*;

  logic [CHW-1:0] ch_q;
  logic [OFW-1:0] off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q  <= '0;
      off_q <= '0;
    end else if (int'(ch_q) == N_CH - 1) begin
      ch_q  <= '0;
      off_q <= (int'(off_q) == CPC - 1) ? '0 : off_q + 1'b1;
    end else begin
      ch_q <= ch_q + 1'b1;
    end
  end

  assign visit_chip = CW'(walk_chip(int'(off_q), int'(ch_q), N_CH));
endmodule

// File: rtl/chipwalk_pick.sv
module chipwalk_pick #(
  parameter int N = 4,
  localparam int XW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [XW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = XW'(i);
    end
  end
endmodule

// File: rtl/chipwalk_sched.sv
module chipwalk_sched #(
  parameter int N_CH       = 2,
  parameter int CPC        = 2,
  parameter int QD         = 4,
  parameter int MAXREQ     = 4,
  parameter int DIE_BITS   = 1,
  parameter int PLANE_BITS = 1,
  localparam int N_CHIP = N_CH * CPC,
  localparam int CW     = (N_CHIP > 1) ? $clog2(N_CHIP) : 1,
  localparam int SW     = (QD > 1) ? $clog2(QD) : 1,
  localparam int IW     = (MAXREQ > 1) ? $clog2(MAXREQ) : 1,
  localparam int NW     = $clog2(MAXREQ + 1),
  localparam int LW     = DIE_BITS + PLANE_BITS,
  localparam int NCAND  = QD * MAXREQ,
  localparam int FW     = $clog2(NCAND)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_fua,
  input  logic [NW-1:0]        in_nreq,
  input  logic [MAXREQ*CW-1:0] in_chip,
  input  logic [MAXREQ*LW-1:0] in_loc,
  input  logic [MAXREQ-1:0]    in_rd,
  output logic                 in_ready,
  output logic [SW-1:0]        adm_slot,
  input  logic [N_CHIP-1:0]    chip_busy,
  input  logic                 cmp_valid,
  input  logic [SW-1:0]        cmp_tag,
  input  logic [IW-1:0]        cmp_idx,
  output logic [N_CHIP-1:0]    cmt_strobe,
  output logic [SW-1:0]        cmt_tag,
  output logic [IW-1:0]        cmt_idx
);
  import chipwalk_pkg::*;

  // slot storage
  logic [QD-1:0]                      valid_q, fua_q;
  logic [QD-1:0][MAXREQ-1:0]          live_q, cmtd_q, done_q, rd_q;
  logic [QD-1:0][MAXREQ-1:0][CW-1:0]  chip_q;
  logic [QD-1:0][MAXREQ-1:0][LW-1:0]  loc_q;
  logic [QD-1:0][QD-1:0]              older_q;   // [a][b]: a arrived before b

  // named internal events
  logic [CW-1:0]             visit_chip;
  logic [QD-1:0][MAXREQ-1:0] pend, head, war_blk;
  logic [QD-1:0]             has_pend, oldest, rel;
  logic                      fua_on;
  logic [NCAND-1:0]          cand;
  logic                      cand_any, commit_go, admit_go;
  logic [FW-1:0]             sel;
  logic [SW-1:0]             sel_slot;
  logic [IW-1:0]             sel_idx;
  logic [MAXREQ-1:0]         adm_live;

  chipwalk_walker #(.N_CH(N_CH), .CPC(CPC)) u_walk (
    .clk(clk), .rst_n(rst_n), .visit_chip(visit_chip)
  );

  chipwalk_pick #(.N(QD)) u_free (
    .req(~valid_q), .any(in_ready), .idx(adm_slot)
  );

  chipwalk_pick #(.N(NCAND)) u_cand (
    .req(cand), .any(cand_any), .idx(sel)
  );

  assign admit_go  = in_valid && in_ready;
  assign commit_go = cand_any && !chip_busy[visit_chip];
  assign sel_slot  = SW'(slot_of(int'(sel), MAXREQ));
  assign sel_idx   = IW'(idx_of(int'(sel), MAXREQ));
  assign fua_on    = |(valid_q & fua_q);

  always_comb begin
    for (int r = 0; r < MAXREQ; r++) adm_live[r] = (r < int'(in_nreq));
  end

  // pending work, age order and release
  always_comb begin
    for (int s = 0; s < QD; s++) begin
      pend[s]     = {MAXREQ{valid_q[s]}} & live_q[s] & ~cmtd_q[s];
      has_pend[s] = |pend[s];
      rel[s]      = valid_q[s] && ((live_q[s] & ~(cmtd_q[s] & done_q[s])) == '0);
    end
    for (int s = 0; s < QD; s++) begin
      oldest[s] = has_pend[s];
      for (int u = 0; u < QD; u++) begin
        if (u != s && has_pend[u] && older_q[u][s]) oldest[s] = 1'b0;
      end
    end
  end

  // head of each slot: lowest pending request index
  always_comb begin
    for (int s = 0; s < QD; s++) begin
      head[s] = pend[s] & ~(pend[s] - 1'b1);
    end
  end

  // write-after-read hold
  always_comb begin
    for (int s = 0; s < QD; s++) begin
      for (int r = 0; r < MAXREQ; r++) begin
        war_blk[s][r] = 1'b0;
        if (!rd_q[s][r]) begin
          for (int u = 0; u < QD; u++) begin
            for (int j = 0; j < MAXREQ; j++) begin
              if (pend[u][j] && rd_q[u][j] &&
                  chip_q[u][j] == chip_q[s][r] && loc_q[u][j] == loc_q[s][r] &&
                  ((u == s) ? (j < r) : older_q[u][s]))
                war_blk[s][r] = 1'b1;
            end
          end
        end
      end
    end
  end

  // candidates for the visited chip
  always_comb begin
    for (int s = 0; s < QD; s++) begin
      for (int r = 0; r < MAXREQ; r++) begin
        cand[flat_of(s, r, MAXREQ)] = pend[s][r] && (chip_q[s][r] == visit_chip) &&
                                      !war_blk[s][r] &&
                                      (!fua_on || (oldest[s] && head[s][r]));
      end
    end
  end

  // state update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q    <= '0;
      fua_q      <= '0;
      live_q     <= '0;
      cmtd_q     <= '0;
      done_q     <= '0;
      rd_q       <= '0;
      chip_q     <= '0;
      loc_q      <= '0;
      older_q    <= '0;
      cmt_strobe <= '0;
      cmt_tag    <= '0;
      cmt_idx    <= '0;
    end else begin
      cmt_strobe <= commit_go ? (N_CHIP'(1) << visit_chip) : '0;
      if (commit_go) begin
        cmt_tag <= sel_slot;
        cmt_idx <= sel_idx;
        cmtd_q[sel_slot][sel_idx] <= 1'b1;
      end
      if (cmp_valid) done_q[cmp_tag][cmp_idx] <= 1'b1;
      for (int s = 0; s < QD; s++) begin
        if (rel[s]) valid_q[s] <= 1'b0;
      end
      if (admit_go) begin
        valid_q[adm_slot] <= 1'b1;
        fua_q[adm_slot]   <= in_fua;
        live_q[adm_slot]  <= adm_live;
        cmtd_q[adm_slot]  <= '0;
        done_q[adm_slot]  <= '0;
        rd_q[adm_slot]    <= in_rd;
        chip_q[adm_slot]  <= in_chip;
        loc_q[adm_slot]   <= in_loc;
        for (int y = 0; y < QD; y++) begin
          older_q[adm_slot][y] <= 1'b0;
          if (y != int'(adm_slot)) older_q[y][adm_slot] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/chipwalk_sched_chk.sv
module chipwalk_sched_chk #(
  parameter int N_CHIP = 4,
  parameter int CW     = 2,
  parameter int QD     = 4,
  parameter int SW     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [SW-1:0]     adm_slot,
  input logic [N_CHIP-1:0] chip_busy,
  input logic              cmp_valid,
  input logic [N_CHIP-1:0] cmt_strobe,
  input logic [CW-1:0]     visit_chip,
  input logic [QD-1:0]     valid_q
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmt_strobe));

  p_walk_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (int'(visit_chip) ==
               ((int'($past(visit_chip)) == N_CHIP - 1) ? 0 : int'($past(visit_chip)) + 1)));

  p_strobe_on_visit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_strobe != '0) |-> (cmt_strobe == (N_CHIP'(1) << $past(visit_chip))));

  p_busy_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_strobe != '0) |-> ((cmt_strobe & $past(chip_busy)) == '0));

  p_admit_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> valid_q[$past(adm_slot)]);

  p_free_after_cmp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(valid_q) & ~valid_q) != '0) |-> $past(cmp_valid, 2));
endmodule

bind chipwalk_sched chipwalk_sched_chk #(
  .N_CHIP(N_CHIP), .CW(CW), .QD(QD), .SW(SW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .adm_slot(adm_slot), .chip_busy(chip_busy), .cmp_valid(cmp_valid),
  .cmt_strobe(cmt_strobe), .visit_chip(visit_chip), .valid_q(valid_q)
);

// File: tb/test_chipwalk_sched.sv
module test_chipwalk_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2, CPC = 2, NCHIP = NCH * CPC;
  localparam int CW = 2, QD = 4, SW = 2, MR = 4, IW = 2, NW = 3, LW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_fua = 1'b0;
  logic [NW-1:0] in_nreq = '0;
  logic [MR*CW-1:0] in_chip = '0;
  logic [MR*LW-1:0] in_loc = '0;
  logic [MR-1:0] in_rd = '0;
  logic in_ready;
  logic [SW-1:0] adm_slot;
  logic [NCHIP-1:0] chip_busy = '1;
  logic cmp_valid = 1'b0;
  logic [SW-1:0] cmp_tag = '0;
  logic [IW-1:0] cmp_idx = '0;
  logic [NCHIP-1:0] cmt_strobe;
  logic [SW-1:0] cmt_tag;
  logic [IW-1:0] cmt_idx;

  chipwalk_sched i_chipwalk_sched (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, n_strobes = 0;
  int exp_q[$];
  bit free_mode = 1'b0;
  int fr_chip[NCHIP], fr_tag[NCHIP], fr_idx[NCHIP], fr_cyc[NCHIP];
  int fr_n = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int strobe_chip(logic [NCHIP-1:0] v);
    int c = -1;
    for (int i = 0; i < NCHIP; i++) if (v[i]) c = i;
    return c;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && cmt_strobe != '0) begin
      int c, got;
      c = strobe_chip(cmt_strobe);
      chk($countones(cmt_strobe) == 1, "R3 single strobe", $countones(cmt_strobe), 1);
      got = c * 256 + int'(cmt_tag) * 16 + int'(cmt_idx);
      if (free_mode) begin
        if (fr_n < NCHIP) begin
          fr_chip[fr_n] = c; fr_tag[fr_n] = int'(cmt_tag);
          fr_idx[fr_n] = int'(cmt_idx); fr_cyc[fr_n] = cyc;
        end
        fr_n++;
      end else if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected commit chip*256+tag*16+idx", got, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(got == e, "R3/R5/R6/R7 commit chip*256+tag*16+idx", got, e);
      end
      n_strobes++;
    end
  end

  function automatic logic [MR*CW-1:0] pk_chip(int a, int b, int c, int d);
    return {CW'(d), CW'(c), CW'(b), CW'(a)};
  endfunction

  task automatic admit(input bit fua, input int nreq, input logic [MR*CW-1:0] chips,
                       input logic [MR*LW-1:0] locs, input logic [MR-1:0] rds, input int exp_slot);
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready before admit", int'(in_ready), 1);
    chk(int'(adm_slot) == exp_slot, "R1 admit slot", int'(adm_slot), exp_slot);
    in_valid = 1'b1; in_fua = fua; in_nreq = NW'(nreq);
    in_chip = chips; in_loc = locs; in_rd = rds;
    @(negedge clk);
    in_valid = 1'b0; in_fua = 1'b0;
  endtask

  task automatic complete(input int slot, input int idx);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_tag = SW'(slot); cmp_idx = IW'(idx);
    @(negedge clk);
    cmp_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_commit(input int c, input int t, input int i);
    exp_q.push_back(c * 256 + t * 16 + i);
  endtask

  task automatic run_chip(input int c, input int n);
    int target;
    @(negedge clk);
    target = n_strobes + n;
    chip_busy[c] = 1'b0;
    wait (n_strobes >= target);
    chip_busy[c] = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 reset ready", int'(in_ready), 1);
    chk(adm_slot == '0, "R1 reset slot", int'(adm_slot), 0);
    chk(cmt_strobe == '0, "R4 reset no strobe", int'(cmt_strobe), 0);

    // fill the queue, all chips busy
    admit(0, 2, pk_chip(1, 3, 0, 0), {2'd0, 2'd0, 2'd1, 2'd0}, 4'b0011, 0);
    admit(0, 2, pk_chip(1, 0, 0, 0), {2'd0, 2'd0, 2'd0, 2'd2}, 4'b0001, 1);
    admit(0, 1, pk_chip(1, 0, 0, 0), {2'd0, 2'd0, 2'd0, 2'd0}, 4'b0000, 2);
    admit(0, 1, pk_chip(0, 0, 0, 0), {2'd0, 2'd0, 2'd0, 2'd3}, 4'b0001, 3);
    @(negedge clk);
    chk(in_ready == 1'b0, "R1 full queue not ready", int'(in_ready), 0);
    s0 = n_strobes;
    repeat (10) @(negedge clk);
    chk(n_strobes == s0, "R4 busy chips get no commit", n_strobes - s0, 0);

    // R5 lowest slot first, tags mixed on chip 1; R7 write after slot0 read
    expect_commit(1, 0, 0); expect_commit(1, 1, 0); expect_commit(1, 2, 0);
    run_chip(1, 3);
    expect_commit(0, 1, 1); expect_commit(0, 3, 0);
    run_chip(0, 2);
    expect_commit(3, 0, 1);
    run_chip(3, 1);
    chk(exp_q.size() == 0, "R9 all phase-1 commits seen", exp_q.size(), 0);

    // R8 release rules
    complete(2, 0);
    chk(in_ready == 1'b1, "R8 slot freed after completion", int'(in_ready), 1);
    chk(int'(adm_slot) == 2, "R8 freed slot number", int'(adm_slot), 2);
    complete(0, 0);
    chk(int'(adm_slot) == 2, "R8 partial slot stays held", int'(adm_slot), 2);

    // R7 with age order opposite to slot order
    admit(0, 1, pk_chip(2, 0, 0, 0), {2'd0, 2'd0, 2'd0, 2'd1}, 4'b0001, 2);
    complete(0, 1);
    complete(3, 0);
    admit(0, 1, pk_chip(2, 0, 0, 0), {2'd0, 2'd0, 2'd0, 2'd1}, 4'b0000, 0);
    expect_commit(2, 2, 0); expect_commit(2, 0, 0);
    run_chip(2, 2);
    complete(1, 0); complete(1, 1); complete(2, 0); complete(0, 0);
    chk(in_ready == 1'b1 && adm_slot == '0, "R8 all slots free", int'(adm_slot), 0);

    // R6 strict order under force-unit-access
    admit(0, 1, pk_chip(0, 0, 0, 0), '0, 4'b0001, 0);
    admit(1, 1, pk_chip(1, 0, 0, 0), '0, 4'b0001, 1);
    @(negedge clk);
    s0 = n_strobes;
    chip_busy[1] = 1'b0;
    repeat (12) @(negedge clk);
    chk(n_strobes == s0, "R6 younger tag held while older pending", n_strobes - s0, 0);
    expect_commit(0, 0, 0); expect_commit(1, 1, 0);
    s0 = n_strobes;
    chip_busy[0] = 1'b0;
    wait (n_strobes >= s0 + 2);
    chip_busy = '1;
    complete(0, 0); complete(1, 0);

    // R2 walk order, R1 admission while the walker runs
    @(negedge clk);
    free_mode = 1'b1;
    chip_busy = '0;
    repeat (3) @(negedge clk);
    admit(0, 4, pk_chip(0, 1, 2, 3), '0, 4'b1111, 0);
    repeat (3 * NCHIP) @(negedge clk);
    chk(fr_n == NCHIP, "R9 one commit per request", fr_n, NCHIP);
    for (int k = 0; k < NCHIP; k++) begin
      chk(fr_idx[k] == fr_chip[k], "R3 strobed chip matches request target", fr_chip[k], fr_idx[k]);
      chk(fr_tag[k] == 0, "R3 commit tag", fr_tag[k], 0);
    end
    for (int k = 1; k < NCHIP; k++) begin
      chk(fr_chip[k] == (fr_chip[k - 1] + 1) % NCHIP, "R2 next chip in walk",
          fr_chip[k], (fr_chip[k - 1] + 1) % NCHIP);
      chk(fr_chip[k] % NCH != fr_chip[k - 1] % NCH, "R2 channel changes per step",
          fr_chip[k] % NCH, fr_chip[k - 1] % NCH);
      chk(fr_cyc[k] == fr_cyc[k - 1] + 1, "R2 one visit per cycle",
          fr_cyc[k] - fr_cyc[k - 1], 1);
    end
    for (int k = 0; k < NCHIP; k++) complete(0, k);
    chk(in_ready == 1'b1 && adm_slot == '0, "R8 drained queue", int'(in_ready), 1);
    chk(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule